// File: doc/BRIEF.md
# Segmented Comparand Loader with Automatic Compare Trigger

This block sits between a narrow 16-bit host data path and the wide registers that feed a content-addressable match array. A wide comparand register and a wide mask register are filled one 16-bit slice at a time. A write segment counter picks the slice for each write. A separate read segment counter picks the slice returned on the read port, so both wide registers can also be read back in narrow pieces. Each counter has its own first and last segment, which the host sets. When a counter steps past its last segment, it goes back to its first segment.

When a comparand or mask write lands on the last write segment, the block pulses a compare strobe toward the match array. A write to the 16-bit control register also pulses the strobe. On command, the comparand rotates by one bit to the left or to the right. This lets software slide a search key without reloading it.

Top module: `seg_cmp_loader`

## Requirements
- R1: After reset, the comparand, mask and control registers are zero, both segment counters are zero and the compare strobe is low.
- R2: A write places wr_data into slice wr_seg of its target, where segment 0 is bits 15:0. The target is set by wr_sel: 0 selects the comparand, 1 selects the mask, 2 selects the control register (all 16 bits) and 3 selects nothing. Every other bit keeps its value.
- R3: After each comparand or mask write, the write counter moves up by one, modulo the segment count. If the counter was at wr_last, it reloads wr_first instead. Control writes and wr_sel=3 writes leave the counter unchanged.
- R4: rd_data shows slice rd_seg of the comparand when rd_sel=0, and of the mask when rd_sel=1. Each rd_en steps the read counter using rd_first and rd_last, in the same way as R3. Writes do not move the read counter.
- R5: seg_restart loads wr_first into the write counter and rd_first into the read counter on the next edge. It overrides any step in that cycle.
- R6: cmp_strobe is high for exactly the one cycle after a comparand or mask write made at wr_seg equal to wr_last, or after any control write. In every other cycle it is low.
- R7: shift_en with shift_right=0 rotates the comparand left by one bit, so that bit 63 moves into bit 0.
- R8: shift_en with shift_right=1 rotates the comparand right by one bit, so that bit 0 moves into bit 63.
- R9: When a comparand write and shift_en arrive in the same cycle, only the write takes effect. A rotation never raises cmp_strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Segment write request |
| wr_sel | input | 2 | Write target code (see R2) |
| wr_data | input | 16 | Write slice |
| rd_en | input | 1 | Advance the read counter |
| rd_sel | input | 1 | Read source: 0 comparand, 1 mask |
| rd_data | output | 16 | Selected read slice |
| seg_restart | input | 1 | Reload both counters from their first segment |
| wr_first | input | 2 | First write segment |
| wr_last | input | 2 | Last write segment |
| rd_first | input | 2 | First read segment |
| rd_last | input | 2 | Last read segment |
| shift_en | input | 1 | Rotate the comparand by one bit |
| shift_right | input | 1 | Rotation direction: 1 right, 0 left |
| cmp_data | output | 64 | Comparand register |
| mask_data | output | 64 | Mask register |
| ctrl_data | output | 16 | Control register |
| cmp_strobe | output | 1 | Single-cycle compare start |
| wr_seg | output | 2 | Current write segment |
| rd_seg | output | 2 | Current read segment |

## Verification
The assertions assume that every input holds a known value on each clock edge after reset. They also assume the bounds inputs may change from one cycle to the next, so the checks take $past of the bound that was sampled. The bench changes its inputs a short time after the falling edge, so every value is steady at the rising edge. In the random phase it keeps each control to legal codes, including the unused write code 3, and it also changes the bounds while transfers are in progress.

// File: rtl/seg_cmp_pkg.sv
package seg_cmp_pkg;
  typedef enum logic [1:0] {
    TGT_CMP  = 2'd0,
    TGT_MASK = 2'd1,
    TGT_CTRL = 2'd2,
    TGT_NONE = 2'd3
  } wr_tgt_e;
endpackage

// File: rtl/seg_counter.sv
module seg_counter #(
  parameter int NSEG = 4,
  localparam int CW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic [CW-1:0] first,
  input  logic [CW-1:0] last,
  output logic [CW-1:0] cnt,
  output logic          at_last
);
  localparam logic [CW-1:0] TOP_IDX = CW'(NSEG - 1);

  function automatic logic [CW-1:0] next_seg(input logic [CW-1:0] cur,
                                             input logic [CW-1:0] lo,
                                             input logic [CW-1:0] hi);
    if (cur == hi)      return lo;
    if (cur == TOP_IDX) return '0;
    return cur + 1'b1;
  endfunction

  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= first;
    else if (step)    cnt <= next_seg(cnt, first, last);
  end

  a_r3_reload_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && at_last) |=> (cnt == $past(first)));
  a_r5_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == $past(first)));
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(cnt));
endmodule

// File: rtl/wide_seg_reg.sv
module wide_seg_reg #(
  parameter int SEG_W  = 16,
  parameter int NSEG   = 4,
  parameter bit ROT_EN = 1'b0,
  localparam int W  = SEG_W * NSEG,
  localparam int CW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CW-1:0]    seg,
  input  logic [SEG_W-1:0] din,
  input  logic             rot,
  input  logic             rot_right,
  output logic [W-1:0]     q
);
  function automatic logic [SEG_W-1:0] get_slice(input logic [W-1:0] v,
                                                 input logic [CW-1:0] s);
    logic [SEG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSEG; i++)
      if (s == CW'(i)) r = v[i*SEG_W +: SEG_W];
    return r;
  endfunction

  logic [W-1:0] wr_next;
  logic [W-1:0] rot_next;
  logic [W-1:0] hole;     // bits a write may touch

  always_comb begin
    wr_next = q;
    hole    = '0;
    for (int i = 0; i < NSEG; i++)
      if (seg == CW'(i)) begin
        wr_next[i*SEG_W +: SEG_W] = din;
        hole[i*SEG_W +: SEG_W]    = '1;
      end
  end

  generate
    if (ROT_EN) begin : g_rot
      assign rot_next = rot_right ? {q[0], q[W-1:1]} : {q[W-2:0], q[W-1]};

      a_r7_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (rot && !wr && !rot_right) |=>
          (q[0] == $past(q[W-1])) && (q[W-1:1] == $past(q[W-2:0])));
      a_r8_rotate_right: assert property (@(posedge clk) disable iff (!rst_n)
        (rot && !wr && rot_right) |=>
          (q[W-1] == $past(q[0])) && (q[W-2:0] == $past(q[W-1:1])));
    end else begin : g_fixed
      assign rot_next = q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (wr)               q <= wr_next;
    else if (ROT_EN && rot)    q <= rot_next;
  end

  a_r2_slice_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (get_slice(q, $past(seg)) == $past(din)));
  a_r2_rest_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((q & ~$past(hole)) == ($past(q) & ~$past(hole))));
  a_r9_write_over_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rot) |=> ((q & ~$past(hole)) == ($past(q) & ~$past(hole))));
endmodule

// File: rtl/cmp_trigger.sv
module cmp_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic seg_wr,
  input  logic seg_at_last,
  input  logic ctrl_wr,
  output logic strobe
);
  logic fire;
  assign fire = (seg_wr && seg_at_last) || ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= 1'b0;
    else        strobe <= fire;
  end

  a_r6_nonterminal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_wr && !seg_at_last && !ctrl_wr) |=> !strobe);
  a_r6_terminal_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_wr && seg_at_last) |=> strobe);
endmodule

// File: rtl/seg_cmp_loader.sv
module seg_cmp_loader #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int W  = SEG_W * NSEG,
  localparam int CW = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [SEG_W-1:0] rd_data,
  input  logic             seg_restart,
  input  logic [CW-1:0]    wr_first,
  input  logic [CW-1:0]    wr_last,
  input  logic [CW-1:0]    rd_first,
  input  logic [CW-1:0]    rd_last,
  input  logic             shift_en,
  input  logic             shift_right,
  output logic [W-1:0]     cmp_data,
  output logic [W-1:0]     mask_data,
  output logic [SEG_W-1:0] ctrl_data,
  output logic             cmp_strobe,
  output logic [CW-1:0]    wr_seg,
  output logic [CW-1:0]    rd_seg
);
  import seg_cmp_pkg::*;

  // named internal events
  logic cmp_wr, mask_wr, ctrl_wr, seg_wr, wr_at_last, rd_at_last;
  assign cmp_wr  = wr_en && (wr_sel == TGT_CMP);
  assign mask_wr = wr_en && (wr_sel == TGT_MASK);
  assign ctrl_wr = wr_en && (wr_sel == TGT_CTRL);
  assign seg_wr  = cmp_wr || mask_wr;

  seg_counter #(.NSEG(NSEG)) u_wr_cnt (
    .clk(clk), .rst_n(rst_n), .restart(seg_restart), .step(seg_wr),
    .first(wr_first), .last(wr_last), .cnt(wr_seg), .at_last(wr_at_last));

  seg_counter #(.NSEG(NSEG)) u_rd_cnt (
    .clk(clk), .rst_n(rst_n), .restart(seg_restart), .step(rd_en),
    .first(rd_first), .last(rd_last), .cnt(rd_seg), .at_last(rd_at_last));

  wide_seg_reg #(.SEG_W(SEG_W), .NSEG(NSEG), .ROT_EN(1'b1)) u_cmp_reg (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .seg(wr_seg), .din(wr_data),
    .rot(shift_en), .rot_right(shift_right), .q(cmp_data));

  wide_seg_reg #(.SEG_W(SEG_W), .NSEG(NSEG), .ROT_EN(1'b0)) u_mask_reg (
    .clk(clk), .rst_n(rst_n), .wr(mask_wr), .seg(wr_seg), .din(wr_data),
    .rot(1'b0), .rot_right(1'b0), .q(mask_data));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_data <= '0;
    else if (ctrl_wr) ctrl_data <= wr_data;
  end

  cmp_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .seg_wr(seg_wr), .seg_at_last(wr_at_last),
    .ctrl_wr(ctrl_wr), .strobe(cmp_strobe));

  // read slice mux
  logic [W-1:0] rd_src;
  assign rd_src = rd_sel ? mask_data : cmp_data;
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSEG; i++)
      if (rd_seg == CW'(i)) rd_data = rd_src[i*SEG_W +: SEG_W];
  end

  a_r6_no_strobe_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> !cmp_strobe);
  a_r4_read_ignores_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !seg_restart && wr_en) |=> $stable(rd_seg));
  a_r3_ctrl_keeps_wr_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !seg_restart) |=> $stable(wr_seg));
  a_r9_shift_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !wr_en) |=> !cmp_strobe);
  a_r1_after_reset: assert property (@(posedge clk)
    !rst_n |=> (cmp_data == '0 && !cmp_strobe && wr_seg == '0 && rd_seg == '0));
endmodule

// File: tb/seg_cmp_loader_tb_top.sv
`timescale 1ns/1ps
module seg_cmp_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, rd_sel = 0, seg_restart = 0, shift_en = 0, shift_right = 0;
  logic [1:0] wr_sel = 0, wr_first = 0, wr_last = 3, rd_first = 0, rd_last = 3;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data, ctrl_data;
  logic [63:0] cmp_data, mask_data;
  logic cmp_strobe;
  logic [1:0] wr_seg, rd_seg;

  always #4 clk = ~clk;

  seg_cmp_loader dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .seg_restart(seg_restart),
    .wr_first(wr_first), .wr_last(wr_last), .rd_first(rd_first), .rd_last(rd_last),
    .shift_en(shift_en), .shift_right(shift_right), .cmp_data(cmp_data),
    .mask_data(mask_data), .ctrl_data(ctrl_data), .cmp_strobe(cmp_strobe),
    .wr_seg(wr_seg), .rd_seg(rd_seg));

  int n_chk = 0, n_bad = 0;
  bit done = 0, armed = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [63:0] m_cmp, m_mask;
  logic [15:0] m_ctrl;
  int m_wr, m_rd;
  bit m_stb;

  function automatic int adv(input int cur, input int lo, input int hi);
    if (cur == hi) return lo;
    return (cur + 1) % 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cmp = 0; m_mask = 0; m_ctrl = 0; m_wr = 0; m_rd = 0; m_stb = 0;
      armed = 1;
    end else begin
      bit trig;
      trig = 0;
      if (wr_en && wr_sel == 2'd0) begin
        m_cmp[m_wr*16 +: 16] = wr_data; trig = (m_wr == int'(wr_last));
      end else if (shift_en) begin
        if (shift_right) m_cmp = {m_cmp[0], m_cmp[63:1]};
        else             m_cmp = {m_cmp[62:0], m_cmp[63]};
      end
      if (wr_en && wr_sel == 2'd1) begin
        m_mask[m_wr*16 +: 16] = wr_data; trig = (m_wr == int'(wr_last));
      end
      if (wr_en && wr_sel == 2'd2) begin m_ctrl = wr_data; trig = 1; end
      if (seg_restart) m_wr = int'(wr_first);
      else if (wr_en && wr_sel < 2) m_wr = adv(m_wr, int'(wr_first), int'(wr_last));
      if (seg_restart) m_rd = int'(rd_first);
      else if (rd_en) m_rd = adv(m_rd, int'(rd_first), int'(rd_last));
      m_stb = trig;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (armed && !done) begin
      logic [63:0] src;
      src = rd_sel ? m_mask : m_cmp;
      chk("R2 cmp_data", cmp_data, m_cmp);
      chk("R2 mask_data", mask_data, m_mask);
      chk("R2 ctrl_data", 64'(ctrl_data), 64'(m_ctrl));
      chk("R3 wr_seg", 64'(wr_seg), 64'(m_wr));
      chk("R4 rd_seg", 64'(rd_seg), 64'(m_rd));
      chk("R4 rd_data", 64'(rd_data), 64'(src[m_rd*16 +: 16]));
      chk("R6 cmp_strobe", 64'(cmp_strobe), 64'(m_stb));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      finish_run();
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask

  task automatic do_wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic do_shift(input logic right);
    shift_en = 1; shift_right = right; tick(); shift_en = 0;
  endtask

  initial begin
    tick(); tick(); tick();
    rst_n = 1;
    chk("R1 reset cmp", cmp_data, 64'h0);
    chk("R1 reset strobe", 64'(cmp_strobe), 64'h0);
    chk("R1 reset counters", 64'({wr_seg, rd_seg}), 64'h0);
    // comparand fill 0..3
    do_wr(2'd0, 16'h1111); do_wr(2'd0, 16'h2222); do_wr(2'd0, 16'h3333);
    chk("R6 no strobe mid-fill", 64'(cmp_strobe), 64'h0);
    do_wr(2'd0, 16'h8444);
    chk("R6 strobe at last seg", 64'(cmp_strobe), 64'h1);
    chk("R2 assembled", cmp_data, 64'h8444_3333_2222_1111);
    chk("R3 wrapped to first", 64'(wr_seg), 64'h0);
    tick();
    chk("R6 single cycle", 64'(cmp_strobe), 64'h0);
    do_shift(1'b0);
    chk("R7 rotl", cmp_data, 64'h0888_6666_4444_2223);
    chk("R9 no strobe on shift", 64'(cmp_strobe), 64'h0);
    do_shift(1'b1);
    chk("R8 rotr back", cmp_data, 64'h8444_3333_2222_1111);
    do_shift(1'b1);
    chk("R8 rotr wrap bit", cmp_data, 64'hC222_1999_9111_0888);
    // write wins over shift
    shift_en = 1; shift_right = 0; do_wr(2'd0, 16'hABCD); shift_en = 0;
    chk("R9 write wins", cmp_data, 64'hC222_1999_9111_ABCD);
    // mask with range 1..2
    wr_first = 1; wr_last = 2; seg_restart = 1; tick(); seg_restart = 0;
    chk("R5 restart wr", 64'(wr_seg), 64'h1);
    do_wr(2'd1, 16'hAAAA); do_wr(2'd1, 16'hBBBB);
    chk("R6 mask terminal strobe", 64'(cmp_strobe), 64'h1);
    do_wr(2'd1, 16'hCCCC);
    chk("R2 mask slices", mask_data, 64'h0000_BBBB_CCCC_0000);
    do_wr(2'd2, 16'h5A5A);
    chk("R6 ctrl strobe", 64'(cmp_strobe), 64'h1);
    chk("R3 ctrl keeps wr_seg", 64'(wr_seg), 64'h2);
    do_wr(2'd3, 16'hFFFF);
    chk("R2 code3 ignored", mask_data, 64'h0000_BBBB_CCCC_0000);
    chk("R6 code3 no strobe", 64'(cmp_strobe), 64'h0);
    // reads over 2..3
    rd_first = 2; rd_last = 3; seg_restart = 1; tick(); seg_restart = 0;
    rd_sel = 1; #1;
    chk("R4 mask read seg2", 64'(rd_data), 64'h0000_0000_0000_BBBB);
    rd_en = 1; tick(); tick(); rd_en = 0; #1;
    chk("R4 read wrap to first", 64'(rd_seg), 64'h2);
    // random phase
    for (int i = 0; i < 600; i++) begin
      wr_en = 1'($urandom); wr_sel = 2'($urandom); wr_data = 16'($urandom);
      rd_en = 1'($urandom); rd_sel = 1'($urandom);
      shift_en = 1'($urandom); shift_right = 1'($urandom);
      seg_restart = ($urandom % 16) == 0;
      if ((i % 50) == 0) begin
        wr_first = 2'($urandom); wr_last = 2'($urandom);
        rd_first = 2'($urandom); rd_last = 2'($urandom);
      end
      tick();
    end
    wr_en = 0; rd_en = 0; shift_en = 0; seg_restart = 0;
    tick(); tick();
    finish_run();
  end
endmodule